// File: doc/BRIEF.md
# Luma Interpolation Window Fetch Controller

This controller gathers, for one 4x4 luma block at a time, the 9x9 patch of reference pixels that a 6-tap half-sample filter (kernel 1, -5, 20, 20, -5, 1) needs around the block. Pixels arrive over a 32-bit read port that carries four 8-bit pixels per beat. A full window column of nine pixels therefore costs three beats, and a block fetched from scratch costs 27 beats.

Blocks of a 16x16 macroblock arrive in column-major order: index bits [1:0] give the block row and bits [3:2] the block column. When the block to the left has the same motion vector, the controller takes the left five window columns from a content buffer that holds the rightmost five columns of the latest block in each block row. When the block just above has the same motion vector, the controller takes the top five rows of every column from the previous window. It then issues only the reads that are still missing and hands the finished window to the filter in one transfer.

Every edge uses a valid/ready handshake. The scan halts whenever the read port or the filter holds back. Read data is taken in the same cycle as the accepted request.

Top module: `mc_win_fetch_ctrl`

## Requirements
- R1: After reset, blk_ready is 1 and rd_valid and win_valid are 0.
- R2: A block without reuse issues exactly 27 reads. Columns go in ascending order, and each column is read as rows 0-3, then 4-7, then row 8 alone, with rd_len of 4, 4 and 1.
- R3: Horizontal reuse applies when the block is not in block column 0, the latest block of the same block row is in the previous block column of the same macroblock, and that block has the same vector and was not split. The block then issues 12 reads, covering only window columns 5 to 8 at full height.
- R4: Vertical reuse applies when the block is not in block row 0, the block accepted just before it is the one directly above (index minus one), and that block has the same vector and was not split. The block then issues 9 reads, one per column, each with rd_row 5 and rd_len 4.
- R5: When both kinds of reuse apply, the block issues 4 reads: columns 5 to 8, rows 5 to 8. win_mode reports bit 0 for horizontal reuse and bit 1 for vertical reuse.
- R6: Whatever reuse applies, pixel (column x, row y) of the window sits at win_data[8*(9*x+y) +: 8] and equals the reference pixel at that window position. Lane i of rd_data carries row rd_row+i.
- R7: A vector mismatch with a neighbour disables reuse from that neighbour.
- R8: A block flagged as part of a 4x4-partitioned macroblock never reuses pixels. Its acceptance discards all held pixels, so no later block can reuse from it or from any earlier block.
- R9: While rd_ready is 0 the read request holds steady. While win_ready is 0 the window and win_valid hold steady.
- R10: blk_ready is high only when idle. Each accepted block yields one window, tagged with its index on win_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Block request valid |
| blk_ready | output | 1 | Controller idle, request accepted |
| blk_idx | input | 4 | Column-major block index within the macroblock |
| blk_mv | input | 20 | Motion vector {vertical, horizontal}, 10 bits each |
| blk_split | input | 1 | Macroblock is partitioned into 4x4 blocks |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted; rd_data valid this cycle |
| rd_col | output | 4 | Window column of the read |
| rd_row | output | 4 | First window row of the read |
| rd_len | output | 3 | Number of pixels used from the beat |
| rd_data | input | 32 | Four pixels, lane 0 in bits 7:0 |
| win_valid | output | 1 | Window ready for the filter |
| win_ready | input | 1 | Filter takes the window |
| win_data | output | 648 | 9x9 window, column-major |
| win_mode | output | 2 | Reuse used: bit 0 horizontal, bit 1 vertical |
| win_idx | output | 4 | Index of the block the window belongs to |

## Verification
A macroblock with one shared vector walks through all four cases (no reuse, vertical only, horizontal only, both). Comparing read counts and addresses tells the cases apart, and comparing every window pixel shows that the reused parts were moved into the right places. A second macroblock with scattered vectors shows that each mismatch switches off exactly the reuse it should. Two split patterns, one fully split and one with a single split block, separate skipping reuse from discarding held pixels. A last macroblock runs with random back-pressure on both ports and checks that requests and windows stay frozen while stalled.

// File: rtl/mc_win_pkg.sv
package mc_win_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHOW  = 2'd2
    } ctl_state_e;

    // beats needed to move a run of pixels over a port of a given lane count
    function automatic int span_beats(input int pixels, input int lanes);
        return (pixels + lanes - 1) / lanes;
    endfunction

endpackage

// File: rtl/mc_win_reuse_sel.sv
module mc_win_reuse_sel #(
    parameter int BLK  = 4,
    parameter int MVW  = 10,
    parameter int RW   = $clog2(BLK),
    parameter int IDXW = 2 * RW
) (
    input  logic [IDXW-1:0]             new_idx,
    input  logic [2*MVW-1:0]            new_mv,
    input  logic                        new_split,
    input  logic                        prev_ok,
    input  logic [IDXW-1:0]             prev_idx,
    input  logic [2*MVW-1:0]            prev_mv,
    input  logic [BLK-1:0]              cb_ok,
    input  logic [BLK-1:0][2*MVW-1:0]   cb_mv,
    input  logic [BLK-1:0][RW-1:0]      cb_col,
    output logic                        use_h,
    output logic                        use_v
);

    logic [RW-1:0] new_r;
    logic [RW-1:0] new_c;

    always_comb begin
        new_r = new_idx[RW-1:0];
        new_c = new_idx[IDXW-1:RW];
        use_v = !new_split && (new_r != '0) && prev_ok
              && (prev_idx == new_idx - IDXW'(1)) && (prev_mv == new_mv);
        use_h = !new_split && (new_c != '0) && cb_ok[new_r]
              && (cb_col[new_r] == new_c - RW'(1)) && (cb_mv[new_r] == new_mv);
    end

endmodule

// File: rtl/mc_win_beat_gen.sv
module mc_win_beat_gen #(
    parameter int WIN  = 9,
    parameter int KEEP = 5,
    parameter int PPB  = 4,
    parameter int CW   = $clog2(WIN + 1),
    parameter int LW   = $clog2(PPB + 1)
) (
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    input  logic          skip_top,
    output logic [LW-1:0] len,
    output logic [CW-1:0] nxt_col,
    output logic [CW-1:0] nxt_row,
    output logic          last
);

    logic [CW:0] row_ext;
    logic [CW:0] adv;
    logic [CW:0] rem;
    logic        col_end;

    always_comb begin
        row_ext = {1'b0, row};
        adv     = row_ext + (CW+1)'(PPB);
        rem     = (CW+1)'(WIN) - row_ext;
        col_end = (adv >= (CW+1)'(WIN));
        len     = (rem > (CW+1)'(PPB)) ? LW'(PPB) : LW'(rem);
        nxt_row = col_end ? (skip_top ? CW'(KEEP) : '0) : adv[CW-1:0];
        nxt_col = col_end ? col + CW'(1) : col;
        last    = col_end && (col == CW'(WIN - 1));
    end

endmodule

// File: rtl/mc_win_fetch_ctrl.sv
module mc_win_fetch_ctrl
    import mc_win_pkg::*;
#(
    parameter int PIXW = 8,
    parameter int MVW  = 10,
    parameter int BUSW = 32,
    parameter int BLK  = 4,
    parameter int TAPS = 6,
    localparam int WIN  = BLK + TAPS - 1,
    localparam int KEEP = WIN - BLK,
    localparam int PPB  = BUSW / PIXW,
    localparam int RW   = $clog2(BLK),
    localparam int IDXW = 2 * RW,
    localparam int CW   = $clog2(WIN + 1),
    localparam int LW   = $clog2(PPB + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blk_valid,
    output logic                      blk_ready,
    input  logic [IDXW-1:0]           blk_idx,
    input  logic [2*MVW-1:0]          blk_mv,
    input  logic                      blk_split,
    output logic                      rd_valid,
    input  logic                      rd_ready,
    output logic [CW-1:0]             rd_col,
    output logic [CW-1:0]             rd_row,
    output logic [LW-1:0]             rd_len,
    input  logic [BUSW-1:0]           rd_data,
    output logic                      win_valid,
    input  logic                      win_ready,
    output logic [WIN*WIN*PIXW-1:0]   win_data,
    output logic [1:0]                win_mode,
    output logic [IDXW-1:0]           win_idx
);

    typedef struct packed {
        ctl_state_e                              st;
        logic                                    h;
        logic                                    v;
        logic [CW-1:0]                           col;
        logic [CW-1:0]                           row;
        logic [IDXW-1:0]                         idx;
        logic [2*MVW-1:0]                        mv;
        logic                                    split;
        logic                                    prev_ok;
        logic [WIN-1:0][WIN-1:0][PIXW-1:0]       win;
        logic [BLK-1:0][KEEP-1:0][WIN-1:0][PIXW-1:0] cb;
        logic [BLK-1:0][2*MVW-1:0]               cb_mv;
        logic [BLK-1:0][RW-1:0]                  cb_col;
        logic [BLK-1:0]                          cb_ok;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [BLK-1:0] cb_ok_in;
    logic           prev_ok_in;
    logic           use_h, use_v;
    logic [LW-1:0]  beat_len;
    logic [CW-1:0]  nxt_col, nxt_row;
    logic           beat_last;
    logic [RW-1:0]  new_r, cur_r, cur_c;

    assign new_r = blk_idx[RW-1:0];
    assign cur_r = s_q.idx[RW-1:0];
    assign cur_c = s_q.idx[IDXW-1:RW];

    // a block with index zero opens a new macroblock: nothing held is usable
    assign cb_ok_in   = (blk_idx == '0) ? '0   : s_q.cb_ok;
    assign prev_ok_in = (blk_idx == '0) ? 1'b0 : s_q.prev_ok;

    mc_win_reuse_sel #(
        .BLK (BLK),
        .MVW (MVW),
        .RW  (RW),
        .IDXW(IDXW)
    ) u_sel (
        .new_idx  (blk_idx),
        .new_mv   (blk_mv),
        .new_split(blk_split),
        .prev_ok  (prev_ok_in),
        .prev_idx (s_q.idx),
        .prev_mv  (s_q.mv),
        .cb_ok    (cb_ok_in),
        .cb_mv    (s_q.cb_mv),
        .cb_col   (s_q.cb_col),
        .use_h    (use_h),
        .use_v    (use_v)
    );

    mc_win_beat_gen #(
        .WIN (WIN),
        .KEEP(KEEP),
        .PPB (PPB),
        .CW  (CW),
        .LW  (LW)
    ) u_beat (
        .col     (s_q.col),
        .row     (s_q.row),
        .skip_top(s_q.v),
        .len     (beat_len),
        .nxt_col (nxt_col),
        .nxt_row (nxt_row),
        .last    (beat_last)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (blk_valid) begin
                    s_d.st      = ST_FETCH;
                    s_d.h       = use_h;
                    s_d.v       = use_v;
                    s_d.idx     = blk_idx;
                    s_d.mv      = blk_mv;
                    s_d.split   = blk_split;
                    s_d.col     = use_h ? CW'(KEEP) : '0;
                    s_d.row     = use_v ? CW'(KEEP) : '0;
                    s_d.cb_ok   = blk_split ? '0 : cb_ok_in;
                    s_d.prev_ok = blk_split ? 1'b0 : prev_ok_in;
                    for (int x = 0; x < WIN; x++) begin
                        for (int y = 0; y < WIN; y++) begin
                            if (use_h && x < KEEP) begin
                                s_d.win[x][y] = s_q.cb[new_r][x][y];
                            end else if (use_v && y < KEEP) begin
                                s_d.win[x][y] = s_q.win[x][y + BLK];
                            end
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (rd_ready) begin
                    for (int i = 0; i < PPB; i++) begin
                        if (LW'(i) < beat_len) begin
                            s_d.win[s_q.col][s_q.row + CW'(i)] = rd_data[PIXW*i +: PIXW];
                        end
                    end
                    s_d.col = nxt_col;
                    s_d.row = nxt_row;
                    if (beat_last) begin
                        s_d.st = ST_SHOW;
                    end
                end
            end
            ST_SHOW: begin
                if (win_ready) begin
                    s_d.st = ST_IDLE;
                    for (int x = 0; x < KEEP; x++) begin
                        s_d.cb[cur_r][x] = s_q.win[x + BLK];
                    end
                    s_d.cb_mv[cur_r]  = s_q.mv;
                    s_d.cb_col[cur_r] = cur_c;
                    s_d.cb_ok[cur_r]  = !s_q.split;
                    s_d.prev_ok       = !s_q.split;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign blk_ready = (s_q.st == ST_IDLE);
    assign rd_valid  = (s_q.st == ST_FETCH);
    assign rd_col    = s_q.col;
    assign rd_row    = s_q.row;
    assign rd_len    = beat_len;
    assign win_valid = (s_q.st == ST_SHOW);
    assign win_mode  = {s_q.v, s_q.h};
    assign win_idx   = s_q.idx;

    always_comb begin
        for (int x = 0; x < WIN; x++) begin
            for (int y = 0; y < WIN; y++) begin
                win_data[PIXW*(x*WIN + y) +: PIXW] = s_q.win[x][y];
            end
        end
    end

    // ---------------- assertions ----------------
    logic [7:0] beat_cnt_q;
    logic [7:0] beat_exp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt_q <= '0;
        end else if (blk_valid && blk_ready) begin
            beat_cnt_q <= '0;
        end else if (rd_valid && rd_ready) begin
            beat_cnt_q <= beat_cnt_q + 8'd1;
        end
    end

    assign beat_exp = 8'((s_q.h ? BLK : WIN) * span_beats(s_q.v ? BLK : WIN, PPB));

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_col) && $stable(rd_row) && $stable(rd_len));

    p_win_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && !win_ready |=> win_valid && $stable(win_data) && $stable(win_idx));

    p_skip_cols_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && win_mode[0] |-> rd_col >= CW'(KEEP));

    p_skip_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && win_mode[1] |-> rd_row >= CW'(KEEP));

    p_split_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && s_q.split |-> win_mode == 2'b00);

    p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_len != '0 && rd_len <= LW'(PPB));

    p_beat_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> beat_cnt_q == beat_exp);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && blk_ready |=> rd_valid && !blk_ready);

endmodule

// File: tb/mc_win_fetch_ctrl_tb.sv
`timescale 1ns/1ps
module mc_win_fetch_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         blk_valid = 1'b0;
    logic         blk_ready;
    logic [3:0]   blk_idx = '0;
    logic [19:0]  blk_mv = '0;
    logic         blk_split = 1'b0;
    logic         rd_valid;
    logic         rd_ready = 1'b0;
    logic [3:0]   rd_col, rd_row;
    logic [2:0]   rd_len;
    logic [31:0]  rd_data = '0;
    logic         win_valid;
    logic         win_ready = 1'b0;
    logic [647:0] win_data;
    logic [1:0]   win_mode;
    logic [3:0]   win_idx;

    always #4 clk = ~clk;

    mc_win_fetch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_idx(blk_idx),
        .blk_mv(blk_mv), .blk_split(blk_split),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_col(rd_col), .rd_row(rd_row),
        .rd_len(rd_len), .rd_data(rd_data),
        .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data),
        .win_mode(win_mode), .win_idx(win_idx)
    );

    int checks = 0;
    int errors = 0;
    int sent = 0;
    int done = 0;
    int beats_seen = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // expected read beats
    int ex_col[$], ex_row[$], ex_len[$];
    // expected blocks
    int qb_idx[$], qb_mx[$], qb_my[$], qb_mode[$], qb_beats[$];
    string qb_tag[$];

    // behavioural reuse bookkeeping for one macroblock
    bit m_ok[16];
    int m_mx[16], m_my[16];
    int last_idx = 0;
    bit last_ok = 1'b0;

    function automatic int pix(input int px, input int py);
        return (px * 37 + py * 11 + ((px ^ py) & 15) * 5) & 255;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_block(input int idx, input int mx, input int my, input bit split, input string pre);
        int c, r, mode, nb;
        bit h, v;
        string tag;
        c = idx / 4;
        r = idx % 4;
        if (idx == 0) begin
            for (int k = 0; k < 16; k++) m_ok[k] = 1'b0;
            last_ok = 1'b0;
        end
        h = !split && c > 0 && m_ok[idx-4] && m_mx[idx-4] == mx && m_my[idx-4] == my;
        v = !split && r > 0 && last_ok && last_idx == idx - 1
            && m_mx[idx-1] == mx && m_my[idx-1] == my;
        mode = (v ? 2 : 0) + (h ? 1 : 0);
        nb = 0;
        for (int col = (h ? 5 : 0); col < 9; col++) begin
            for (int row = (v ? 5 : 0); row < 9; row += 4) begin
                ex_col.push_back(col);
                ex_row.push_back(row);
                ex_len.push_back((9 - row) < 4 ? (9 - row) : 4);
                nb++;
            end
        end
        case (mode)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        if (split) begin
            for (int k = 0; k < 16; k++) m_ok[k] = 1'b0;
            last_ok = 1'b0;
        end else begin
            m_ok[idx] = 1'b1;
            m_mx[idx] = mx;
            m_my[idx] = my;
            last_idx = idx;
            last_ok = 1'b1;
        end
        @(negedge clk);
        blk_valid = 1'b1;
        blk_idx = 4'(idx);
        blk_mv = {10'(my), 10'(mx)};
        blk_split = split;
        while (!blk_ready) @(negedge clk);
        qb_idx.push_back(idx); qb_mx.push_back(mx); qb_my.push_back(my);
        qb_mode.push_back(mode); qb_beats.push_back(nb);
        qb_tag.push_back({pre, tag});
        sent++;
        @(negedge clk);
        blk_valid = 1'b0;
        while (done < sent) @(negedge clk);
    endtask

    // monitor and responder, all on the falling edge
    bit rd_held = 1'b0, win_held = 1'b0;
    logic [3:0] h_col, h_row;
    logic [2:0] h_len;
    logic [647:0] h_win;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_held) begin
                chk(rd_valid && rd_col == h_col && rd_row == h_row && rd_len == h_len,
                    "R9 read held", int'(rd_col), int'(h_col));
            end
            if (win_held) begin
                chk(win_valid && win_data == h_win, "R9 window held", int'(win_valid), 1);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_ready = stall_en ? lfsr[0] : 1'b1;
            win_ready = stall_en ? lfsr[3] : 1'b1;
            rd_held = rd_valid && !rd_ready;
            win_held = win_valid && !win_ready;
            h_col = rd_col; h_row = rd_row; h_len = rd_len; h_win = win_data;
            rd_data = '0;
            if (rd_valid && rd_ready) begin
                if (ex_col.size() == 0 || qb_idx.size() == 0) begin
                    chk(1'b0, "R10 unexpected read", int'(rd_col), -1);
                end else begin
                    int ec, er, el, bc, br;
                    ec = ex_col.pop_front();
                    er = ex_row.pop_front();
                    el = ex_len.pop_front();
                    chk(rd_col == 4'(ec) && rd_row == 4'(er) && rd_len == 3'(el),
                        qb_tag[0], int'(rd_col) * 100 + int'(rd_row) * 10 + int'(rd_len),
                        ec * 100 + er * 10 + el);
                    bc = (qb_idx[0] / 4) * 4 + qb_mx[0];
                    br = (qb_idx[0] % 4) * 4 + qb_my[0];
                    for (int i = 0; i < 4; i++) begin
                        if (int'(rd_row) + i < 9)
                            rd_data[8*i +: 8] = 8'(pix(bc + int'(rd_col), br + int'(rd_row) + i));
                    end
                    beats_seen++;
                end
            end
            if (win_valid && win_ready) begin
                if (qb_idx.size() == 0) begin
                    chk(1'b0, "R10 unexpected window", int'(win_idx), -1);
                end else begin
                    int bad, bc, br;
                    bad = 0;
                    bc = (qb_idx[0] / 4) * 4 + qb_mx[0];
                    br = (qb_idx[0] % 4) * 4 + qb_my[0];
                    for (int x = 0; x < 9; x++)
                        for (int y = 0; y < 9; y++)
                            if (win_data[8*(9*x+y) +: 8] != 8'(pix(bc + x, br + y))) bad++;
                    chk(bad == 0, "R6 window pixels", bad, 0);
                    chk(win_idx == 4'(qb_idx[0]), "R10 window index", int'(win_idx), qb_idx[0]);
                    chk(int'(win_mode) == qb_mode[0], qb_tag[0], int'(win_mode), qb_mode[0]);
                    chk(beats_seen == qb_beats[0], qb_tag[0], beats_seen, qb_beats[0]);
                    beats_seen = 0;
                    void'(qb_idx.pop_front()); void'(qb_mx.pop_front()); void'(qb_my.pop_front());
                    void'(qb_mode.pop_front()); void'(qb_beats.pop_front()); void'(qb_tag.pop_front());
                    done++;
                end
            end
        end
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(blk_ready == 1'b1, "R1 ready after reset", int'(blk_ready), 1);
        chk(rd_valid == 1'b0, "R1 no read in reset", int'(rd_valid), 0);
        chk(win_valid == 1'b0, "R1 no window in reset", int'(win_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(blk_ready && !rd_valid && !win_valid, "R1 idle after reset", int'(blk_ready), 1);

        // one shared vector: every reuse case in turn
        for (int k = 0; k < 16; k++) send_block(k, 1, 2, 1'b0, "");
        // scattered vectors break chosen neighbours
        for (int k = 0; k < 16; k++)
            send_block(k, (k == 5 || k == 10) ? -3 : 7, -2, 1'b0, "R7 ");
        // fully partitioned macroblock
        for (int k = 0; k < 16; k++) send_block(k, 4, 4, 1'b1, "R8 ");
        // single split block in the middle
        for (int k = 0; k < 16; k++) send_block(k, -5, 3, (k == 5), "R8 ");
        // back-pressure on both sides
        stall_en = 1'b1;
        for (int k = 0; k < 16; k++) send_block(k, 2, -6, 1'b0, "R9 ");
        stall_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(ex_col.size() == 0, "R10 no leftover reads", ex_col.size(), 0);
        chk(blk_ready == 1'b1, "R10 idle at end", int'(blk_ready), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule